// File: doc/BRIEF.md
# Reconfigurable Instruction Dispatch Arbiter

This block sits between instruction fetch and execution in a processor that pairs a fixed core with a reconfigurable fabric. Each fetched 32-bit word arrives on a valid/ready handshake and is decoded by its six-bit major opcode. Three opcode values select the reconfiguration class: partial set, complete set and execute. Every other opcode is an ordinary instruction and is passed unchanged to the fixed functional units through the core-issue port.

A reconfiguration-class word does not name an operation. It carries a resident/pageable flag and a 25-bit pointer to microcode. The arbiter captures the flag and the pointer and raises a request to the microcode unit, together with a two-bit phase code. The request stays up, and all further issue is blocked, until the microcode unit returns a one-cycle done pulse. The next instruction can be accepted in the cycle after that pulse.

Top module: `rcfg_dispatch`

## Requirements
- R1: After reset, mc_req and core_valid are low and in_ready is high when core_ready is high.
- R2: A word whose opcode field in_word[31:26] is not one of the three reconfiguration values is presented on core_word unchanged, with core_valid high in the same cycle, while the arbiter is idle.
- R3: For an ordinary word, in_ready equals core_ready, so a low core_ready holds the word at the input.
- R4: Opcode 6'h38 (partial set) yields phase 2'b00, 6'h39 (complete set) yields 2'b01 and 6'h3A (execute) yields 2'b10; phase 2'b11 never appears.
- R5: On a microcode request, mc_resident equals in_word[25] and mc_addr equals in_word[24:0] of the accepted word, and all request fields stay stable until done.
- R6: mc_req rises in the cycle after a reconfiguration word is accepted; in_ready stays low from then through the cycle of the mc_done pulse and is high again in the following cycle.
- R7: core_valid stays low while a microcode request is outstanding.
- R8: An mc_done pulse while no request is outstanding has no effect: mc_req stays low and ordinary issue continues.
- R9: A reconfiguration word is never presented on the core-issue port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetched word valid |
| in_ready | output | 1 | Arbiter accepts the word this cycle |
| in_word | input | 32 | Fetched instruction word |
| core_valid | output | 1 | Ordinary instruction offered to the fixed units |
| core_ready | input | 1 | Fixed units take the offered instruction |
| core_word | output | 32 | Ordinary instruction word |
| mc_req | output | 1 | Microcode operation outstanding |
| mc_phase | output | 2 | 00 partial set, 01 complete set, 10 execute |
| mc_resident | output | 1 | Resident (1) or pageable (0) microcode |
| mc_addr | output | 25 | Microcode location pointer |
| mc_done | input | 1 | One-cycle completion pulse from the microcode unit |

## Verification
On every cycle the assertions check that the request fields hold still while a request waits, that input ready and core issue stay low during a request, that the request drops right after done and that the phase code is legal. Only the bench scenarios show the mapping of each opcode to its phase, the exact cycle in which input ready returns, that the flag and pointer bits come from the right positions, and that a stray done leaves the arbiter untouched.

// File: rtl/rd_pkg.sv
package rd_pkg;
   typedef enum logic [1:0] {
      PH_PSET = 2'b00,
      PH_CSET = 2'b01,
      PH_EXEC = 2'b10
   } rd_phase_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } rd_state_e;
endpackage

// File: rtl/rd_decode.sv
module rd_decode #(
   parameter int INSTR_W = 32,
   parameter int OPC_W   = 6,
   parameter int ADDR_W  = 25,
   parameter logic [OPC_W-1:0] OPC_PSET = 6'h38,
   parameter logic [OPC_W-1:0] OPC_CSET = 6'h39,
   parameter logic [OPC_W-1:0] OPC_EXEC = 6'h3A
) (
   input  logic [INSTR_W-1:0] word,
   output logic               is_mc,
   output logic [1:0]         phase,
   output logic               resident,
   output logic [ADDR_W-1:0]  addr
);
   import rd_pkg::*;

   localparam int OPC_LSB = INSTR_W - OPC_W;
   localparam int RES_BIT = ADDR_W;

   if (OPC_W + 1 + ADDR_W != INSTR_W) begin : g_bad_layout
      $error("rd_decode: field widths do not fill the word");
   end
   if (OPC_PSET == OPC_CSET || OPC_PSET == OPC_EXEC || OPC_CSET == OPC_EXEC) begin : g_bad_opc
      $error("rd_decode: reconfiguration opcodes must be distinct");
   end

   logic [OPC_W-1:0] opc;
   assign opc      = word[INSTR_W-1:OPC_LSB];
   assign resident = word[RES_BIT];
   assign addr     = word[ADDR_W-1:0];

   always_comb begin
      is_mc = 1'b1;
      phase = PH_PSET;
      if (opc == OPC_PSET)      phase = PH_PSET;
      else if (opc == OPC_CSET) phase = PH_CSET;
      else if (opc == OPC_EXEC) phase = PH_EXEC;
      else                      is_mc = 1'b0;
   end

   always_comb begin
      assert_phase_code_R4: assert (!is_mc || phase != 2'b11)
         else $error("illegal phase code from decode");
   end
endmodule

// File: rtl/rd_mc_ctrl.sv
module rd_mc_ctrl #(
   parameter int ADDR_W = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [1:0]        phase_in,
   input  logic              res_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              done,
   output logic              req,
   output logic [1:0]        phase,
   output logic              resident,
   output logic [ADDR_W-1:0] addr,
   output logic              idle
);
   import rd_pkg::*;

   rd_state_e st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         phase    <= '0;
         resident <= 1'b0;
         addr     <= '0;
      end else begin
         case (st)
            ST_IDLE: if (take) begin
               st       <= ST_BUSY;
               phase    <= phase_in;
               resident <= res_in;
               addr     <= addr_in;
            end
            ST_BUSY: if (done) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req  = (st == ST_BUSY);
   assign idle = (st == ST_IDLE);

   assert_fields_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req && !done |=> req && $stable(addr) && $stable(resident) && $stable(phase))
      else $error("request fields moved before done");

   assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req && done |=> !req)
      else $error("request held after done");

   assert_stray_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !req && !take |=> !req)
      else $error("request rose without an accepted word");

   assert_phase_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> phase != 2'b11)
      else $error("illegal phase on request");
endmodule

// File: rtl/rd_core_stage.sv
module rd_core_stage #(
   parameter int INSTR_W  = 32,
   parameter bit CORE_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               s_valid,
   input  logic [INSTR_W-1:0] s_word,
   output logic               s_ready,
   output logic               m_valid,
   output logic [INSTR_W-1:0] m_word,
   input  logic               m_ready
);
   if (CORE_REG) begin : g_reg
      logic               v_q;
      logic [INSTR_W-1:0] w_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            w_q <= '0;
         end else if (s_ready) begin
            v_q <= s_valid;
            if (s_valid) w_q <= s_word;
         end
      end
      assign s_ready = !v_q || m_ready;
      assign m_valid = v_q;
      assign m_word  = w_q;

      assert_hold_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
         m_valid && !m_ready |=> m_valid && $stable(m_word))
         else $error("buffered core word dropped");
   end else begin : g_pass
      logic unused_pass;
      assign unused_pass = clk ^ rst_n;
      assign s_ready = m_ready;
      assign m_valid = s_valid;
      assign m_word  = s_word;
   end
endmodule

// File: rtl/rcfg_dispatch.sv
module rcfg_dispatch #(
   parameter int INSTR_W  = 32,
   parameter int OPC_W    = 6,
   parameter int ADDR_W   = 25,
   parameter logic [OPC_W-1:0] OPC_PSET = 6'h38,
   parameter logic [OPC_W-1:0] OPC_CSET = 6'h39,
   parameter logic [OPC_W-1:0] OPC_EXEC = 6'h3A,
   parameter bit CORE_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [INSTR_W-1:0] in_word,
   output logic               core_valid,
   input  logic               core_ready,
   output logic [INSTR_W-1:0] core_word,
   output logic               mc_req,
   output logic [1:0]         mc_phase,
   output logic               mc_resident,
   output logic [ADDR_W-1:0]  mc_addr,
   input  logic               mc_done
);
   logic              dec_mc, dec_res, idle, s_valid, s_ready, take;
   logic [1:0]        dec_phase;
   logic [ADDR_W-1:0] dec_addr;

   rd_decode #(
      .INSTR_W(INSTR_W), .OPC_W(OPC_W), .ADDR_W(ADDR_W),
      .OPC_PSET(OPC_PSET), .OPC_CSET(OPC_CSET), .OPC_EXEC(OPC_EXEC)
   ) u_dec (
      .word(in_word), .is_mc(dec_mc), .phase(dec_phase),
      .resident(dec_res), .addr(dec_addr)
   );

   assign s_valid  = in_valid && idle && !dec_mc;
   assign in_ready = idle && (dec_mc || s_ready);
   assign take     = in_valid && in_ready && dec_mc;

   rd_core_stage #(.INSTR_W(INSTR_W), .CORE_REG(CORE_REG)) u_core (
      .clk(clk), .rst_n(rst_n),
      .s_valid(s_valid), .s_word(in_word), .s_ready(s_ready),
      .m_valid(core_valid), .m_word(core_word), .m_ready(core_ready)
   );

   rd_mc_ctrl #(.ADDR_W(ADDR_W)) u_mc (
      .clk(clk), .rst_n(rst_n), .take(take),
      .phase_in(dec_phase), .res_in(dec_res), .addr_in(dec_addr),
      .done(mc_done), .req(mc_req), .phase(mc_phase),
      .resident(mc_resident), .addr(mc_addr), .idle(idle)
   );

   assert_block_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mc_req |-> !in_ready)
      else $error("input accepted during microcode request");

   if (!CORE_REG) begin : g_quiet
      assert_core_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
         mc_req |-> !core_valid)
         else $error("core issue during microcode request");
   end
endmodule

// File: tb/tb_rcfg_dispatch.sv
module tb_rcfg_dispatch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_word = '0;
   logic        core_valid;
   logic        core_ready = 1'b1;
   logic [31:0] core_word;
   logic        mc_req;
   logic [1:0]  mc_phase;
   logic        mc_resident;
   logic [24:0] mc_addr;
   logic        mc_done = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   rcfg_dispatch dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .core_valid(core_valid), .core_ready(core_ready),
      .core_word(core_word), .mc_req(mc_req), .mc_phase(mc_phase),
      .mc_resident(mc_resident), .mc_addr(mc_addr), .mc_done(mc_done)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   function automatic logic [31:0] mk(input logic [5:0] op, input logic r, input logic [24:0] a);
      return {op, r, a};
   endfunction

   task automatic t_reset();
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      check(mc_req == 0, "R1 mc_req", mc_req, 0);
      check(core_valid == 0, "R1 core_valid", core_valid, 0);
      check(in_ready == 1, "R1 in_ready", in_ready, 1);
   endtask

   task automatic t_core_pass(input logic [31:0] w);
      in_word = w; in_valid = 1'b1; core_ready = 1'b1;
      #1;
      check(core_valid == 1, "R2 core_valid", core_valid, 1);
      check(core_word == w, "R2 core_word", core_word, w);
      check(in_ready == 1, "R3 in_ready", in_ready, 1);
      tick();
      in_valid = 1'b0;
   endtask

   task automatic t_backpressure();
      in_word = mk(6'h05, 1'b1, 25'h0ABCDE); in_valid = 1'b1; core_ready = 1'b0;
      #1;
      check(in_ready == 0, "R3 in_ready blocked", in_ready, 0);
      check(core_valid == 1, "R3 core_valid offered", core_valid, 1);
      tick();
      core_ready = 1'b1;
      #1;
      check(in_ready == 1, "R3 in_ready released", in_ready, 1);
      tick();
      in_valid = 1'b0;
   endtask

   task automatic t_mc(input logic [5:0] op, input logic [1:0] ph, input logic r, input logic [24:0] a);
      in_word = mk(op, r, a); in_valid = 1'b1; core_ready = 1'b1;
      #1;
      check(core_valid == 0, "R9 no core issue", core_valid, 0);
      check(mc_req == 0, "R6 req not yet", mc_req, 0);
      tick();
      in_word = mk(6'h01, 1'b0, 25'h1); in_valid = 1'b1;
      #1;
      check(mc_req == 1, "R6 req raised", mc_req, 1);
      check(mc_phase == ph, "R4 phase", mc_phase, ph);
      check(mc_resident == r, "R5 resident", mc_resident, r);
      check(mc_addr == a, "R5 addr", mc_addr, a);
      check(in_ready == 0, "R6 in_ready low", in_ready, 0);
      check(core_valid == 0, "R7 core quiet", core_valid, 0);
      repeat (3) tick();
      check(mc_addr == a && mc_req == 1, "R5 held", mc_addr, a);
      mc_done = 1'b1;
      #1;
      check(in_ready == 0, "R6 in_ready low at done", in_ready, 0);
      tick();
      mc_done = 1'b0;
      #1;
      check(mc_req == 0, "R6 req dropped", mc_req, 0);
      check(in_ready == 1, "R6 in_ready back", in_ready, 1);
      check(core_valid == 1, "R2 core after mc", core_valid, 1);
      tick();
      in_valid = 1'b0;
   endtask

   task automatic t_stray_done();
      mc_done = 1'b1;
      tick();
      mc_done = 1'b0;
      #1;
      check(mc_req == 0, "R8 no req", mc_req, 0);
      check(in_ready == 1, "R8 in_ready", in_ready, 1);
      t_core_pass(32'h1234_5678);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_core_pass(32'h0400_0001);
      t_core_pass(mk(6'h3B, 1'b1, 25'h1FFFFFF));
      t_core_pass(mk(6'h37, 1'b0, 25'h0));
      t_backpressure();
      t_mc(6'h38, 2'b00, 1'b1, 25'h1234567);
      t_mc(6'h39, 2'b01, 1'b0, 25'h0000001);
      t_mc(6'h3A, 2'b10, 1'b1, 25'h1FFFFFF);
      t_stray_done();
      finish_run();
   end

   initial begin
      #(8 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end
endmodule